// File: doc/BRIEF.md
# Twin-Port Configurable Block Memory

This block is a synthesizable behavioural model of a true dual-port block memory. The two ports, A and B, share one storage array but are configured independently: each has its own clock and synchronous reset, its own user data width and address width, a fixed 3-bit select code, a choice of what a write returns, and an optional output register. A port takes one request per cycle (enable, select, write flag, address, data). It returns read data together with a single-cycle valid strobe at a fixed latency.

Requested data widths are rounded up to one of the native widths 1, 2, 4, 9 or 18. The storage is one flat bit space. Word `k` of a port with native width `H` occupies bits `k*H` to `k*H+H-1`, so ports of different widths see the same bits through different word views. Larger memories are built by tying the request buses of several blocks together and giving each block a different select code. Collisions between the ports on the same bits are not resolved.

Top module: `dpb_ram`

## Requirements
- R1: A user data width W is rounded up to the smallest native width H in {1, 2, 4, 9, 18}. Write data is zero-extended from W to H bits, and read data is the low W bits of the stored H-bit word.
- R2: The address width of a port may be at most 14, 13, 12, 11 or 10 bits for H = 1, 2, 4, 9 or 18. A wider address, a width above 18, or the old-value write mode on a width other than 9 or 18 stops elaboration. Every address from 0 to 2^AW-1 selects its own word.
- R3: A request whose 3-bit select input differs from the port's select parameter is ignored. It writes nothing and produces no result.
- R4: A result appears 1 cycle after the clock edge that samples the request when the output register is off, and 2 cycles after that edge when the register is on.
- R5: In quiet mode (mode code 0) a write produces no result. An accepted read produces the stored word in every mode.
- R6: In new-value mode (mode code 1) a write returns the data just written, truncated to W bits.
- R7: In old-value mode (mode code 2) a write returns the word that it overwrote. A later read returns the new data.
- R8: Each accepted read, and each accepted write in a result-producing mode, raises the valid strobe for exactly one cycle. Back-to-back requests give back-to-back strobes.
- R9: While valid is low, the read data holds the value of the last result.
- R10: A port with user width 0 is disabled. Its valid output and read data stay 0 whatever its inputs do.
- R11: Both ports address one flat bit store. A write through one port is visible to a later read through the other port, even when their native widths differ.
- R12: Reset is synchronous and per port. It clears the valid strobe, any result still in the pipeline, and the held read data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous reset, active high |
| a_en | input | 1 | Port A request enable |
| a_cs | input | 3 | Port A select code presented with the request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | A_ADDR_W | Port A word address |
| a_wdata | input | max(A_DATA_W,1) | Port A write data |
| a_rdata | output | max(A_DATA_W,1) | Port A result data |
| a_rvalid | output | 1 | Port A one-cycle result strobe |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous reset, active high |
| b_en | input | 1 | Port B request enable |
| b_cs | input | 3 | Port B select code presented with the request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | B_ADDR_W | Port B word address |
| b_wdata | input | max(B_DATA_W,1) | Port B write data |
| b_rdata | output | max(B_DATA_W,1) | Port B result data |
| b_rvalid | output | 1 | Port B one-cycle result strobe |

## Verification
The hardest case to reach is a result that is still in flight when reset hits it. This happens when a request on the registered-output port has been sampled but its result has not yet left the second stage. The stimulus samples a read on that port and raises reset on the very next cycle. It then confirms that no strobe ever appears and that the held data returns to 0. The mixed-width view of the shared bits is reached by writing 18-bit words on one port and reading them back as 9-bit halves on the other. An old-value write then lands inside one of those halves, which also shows the zero-extended top bit through the wide port.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  // What a write hands back on the result port.
  typedef enum logic [1:0] {
    WM_QUIET    = 2'd0,  // writes return nothing
    WM_ECHO_NEW = 2'd1,  // writes return the data written
    WM_ECHO_OLD = 2'd2   // writes return the data replaced
  } wmode_e;

  // R1: native width chosen for a requested user width (0 = disabled, -1 = illegal)
  function automatic int hw_width(input int w);
    if (w <= 0)  return 0;
    if (w <= 1)  return 1;
    if (w <= 2)  return 2;
    if (w <= 4)  return 4;
    if (w <= 9)  return 9;
    if (w <= 18) return 18;
    return -1;
  endfunction

  // R2: widest address a native width can use
  function automatic int addr_limit(input int hw);
    case (hw)
      1:       return 14;
      2:       return 13;
      4:       return 12;
      9:       return 11;
      18:      return 10;
      default: return 0;
    endcase
  endfunction

  function automatic bit mode_legal(input wmode_e m, input int hw);
    return (m != WM_ECHO_OLD) || (hw == 9) || (hw == 18);
  endfunction

  function automatic int port_latency(input bit outreg);
    return outreg ? 2 : 1;
  endfunction

  // bits of the flat store covered by one port
  function automatic int span_bits(input int aw, input int hw);
    return (hw > 0) ? (1 << aw) * hw : 0;
  endfunction

  function automatic int max_int(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // does an accepted request produce a result
  function automatic logic emits(input wmode_e m, input logic we);
    return !we || (m != WM_QUIET);
  endfunction

endpackage

// File: rtl/dpb_cfg_guard.sv
// Elaboration-time legality check for one port (R2).
module dpb_cfg_guard
  import dpb_pkg::*;
#(
  parameter int     DW   = 8,
  parameter int     AW   = 6,
  parameter wmode_e MODE = WM_QUIET
);
  localparam int HW = hw_width(DW);

  if (HW < 0) begin : g_bad_width
    $error("dpb_cfg_guard: data width %0d exceeds 18", DW);
  end
  if (HW > 0 && AW < 1) begin : g_bad_aw_low
    $error("dpb_cfg_guard: address width must be at least 1");
  end
  if (HW > 0 && AW > addr_limit(HW)) begin : g_bad_aw_high
    $error("dpb_cfg_guard: address width %0d too wide for native width %0d", AW, HW);
  end
  if (HW > 0 && !mode_legal(MODE, HW)) begin : g_bad_mode
    $error("dpb_cfg_guard: old-value write mode needs native width 9 or 18, got %0d", HW);
  end
endmodule

// File: rtl/dpb_out_stage.sv
// Result stage: one-cycle pass or registered, with a hold register (R4, R9, R12).
module dpb_out_stage #(
  parameter int DW     = 8,
  parameter bit OUTREG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)           held <= '0;
    else if (in_valid) held <= in_data;
  end

  if (OUTREG) begin : g_reg
    logic valid_q;
    always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= in_valid;
    end
    assign out_valid = valid_q;
    assign out_data  = held;
  end else begin : g_pass
    assign out_valid = in_valid;
    assign out_data  = in_valid ? in_data : held;
  end
endmodule

// File: rtl/dpb_port.sv
// One memory port: request registers, its own XOR bank, result selection.
module dpb_port
  import dpb_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         HW       = 9,
  parameter int         AW       = 6,
  parameter int         MEM_BITS = 576,
  parameter logic [2:0] CS       = 3'd0,
  parameter wmode_e     MODE     = WM_QUIET,
  parameter bit         OUTREG   = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [2:0]          cs,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [MEM_BITS-1:0] peer_bank,
  output logic [MEM_BITS-1:0] own_bank,
  output logic                accept_q,
  output logic                emit,
  output logic [DW-1:0]       rdata,
  output logic                rvalid
);
  localparam int IW = (MEM_BITS > 1) ? $clog2(MEM_BITS) : 1;

  logic          q_we;
  logic [AW-1:0] q_addr;
  logic [HW-1:0] q_din;
  logic [IW-1:0] base;
  logic [HW-1:0] cur_word;
  logic [HW-1:0] pre_word;

  // R11: first bit of a word in the flat store
  function automatic logic [IW-1:0] word_base(input logic [AW-1:0] a);
    return IW'(a) * IW'(HW);
  endfunction

  // requests are always registered before touching the store (R3 select compare)
  always_ff @(posedge clk) begin
    if (rst) accept_q <= 1'b0;
    else     accept_q <= en && (cs == CS);
    q_we   <= we;
    q_addr <= addr;
    q_din  <= HW'(wdata);  // R1 zero-extend
  end

  assign base     = word_base(q_addr);
  // stored word = own bank XOR peer bank
  assign cur_word = own_bank[base +: HW] ^ peer_bank[base +: HW];

  always_ff @(posedge clk) begin
    if (accept_q && q_we) own_bank[base +: HW] <= q_din ^ peer_bank[base +: HW];
  end

  assign emit     = accept_q && emits(MODE, q_we);
  assign pre_word = (q_we && (MODE == WM_ECHO_NEW)) ? q_din : cur_word;

  dpb_out_stage #(.DW(DW), .OUTREG(OUTREG)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (emit),
    .in_data  (DW'(pre_word)),  // R1 truncate
    .out_valid(rvalid),
    .out_data (rdata)
  );
endmodule

// File: rtl/dpb_ram.sv
module dpb_ram
  import dpb_pkg::*;
#(
  parameter int         A_DATA_W = 8,
  parameter int         A_ADDR_W = 6,
  parameter logic [2:0] A_CS     = 3'd5,
  parameter wmode_e     A_MODE   = WM_ECHO_OLD,
  parameter bit         A_OUTREG = 1'b0,
  parameter int         B_DATA_W = 18,
  parameter int         B_ADDR_W = 5,
  parameter logic [2:0] B_CS     = 3'd2,
  parameter wmode_e     B_MODE   = WM_ECHO_NEW,
  parameter bit         B_OUTREG = 1'b1
) (
  input  logic                                  a_clk,
  input  logic                                  a_rst,
  input  logic                                  a_en,
  input  logic [2:0]                            a_cs,
  input  logic                                  a_we,
  input  logic [A_ADDR_W-1:0]                   a_addr,
  input  logic [(A_DATA_W>0?A_DATA_W:1)-1:0]    a_wdata,
  output logic [(A_DATA_W>0?A_DATA_W:1)-1:0]    a_rdata,
  output logic                                  a_rvalid,
  input  logic                                  b_clk,
  input  logic                                  b_rst,
  input  logic                                  b_en,
  input  logic [2:0]                            b_cs,
  input  logic                                  b_we,
  input  logic [B_ADDR_W-1:0]                   b_addr,
  input  logic [(B_DATA_W>0?B_DATA_W:1)-1:0]    b_wdata,
  output logic [(B_DATA_W>0?B_DATA_W:1)-1:0]    b_rdata,
  output logic                                  b_rvalid
);
  localparam int A_HW     = hw_width(A_DATA_W);
  localparam int B_HW     = hw_width(B_DATA_W);
  localparam int A_PW     = (A_DATA_W > 0) ? A_DATA_W : 1;
  localparam int B_PW     = (B_DATA_W > 0) ? B_DATA_W : 1;
  localparam bit A_ON     = (A_HW > 0);
  localparam bit B_ON     = (B_HW > 0);
  localparam int A_LAT    = port_latency(A_OUTREG);
  localparam int B_LAT    = port_latency(B_OUTREG);
  localparam int MEM_BITS = max_int(1, max_int(span_bits(A_ADDR_W, A_HW), span_bits(B_ADDR_W, B_HW)));

  // R2 legality checks
  dpb_cfg_guard #(.DW(A_DATA_W), .AW(A_ADDR_W), .MODE(A_MODE)) u_guard_a ();
  dpb_cfg_guard #(.DW(B_DATA_W), .AW(B_ADDR_W), .MODE(B_MODE)) u_guard_b ();

  logic [MEM_BITS-1:0] bank_a;
  logic [MEM_BITS-1:0] bank_b;
  // internal events brought out for the checker
  logic a_accept_q, a_emit;
  logic b_accept_q, b_emit;

  if (A_ON) begin : g_a
    dpb_port #(
      .DW(A_DATA_W), .HW(A_HW), .AW(A_ADDR_W), .MEM_BITS(MEM_BITS),
      .CS(A_CS), .MODE(A_MODE), .OUTREG(A_OUTREG)
    ) u_port (
      .clk(a_clk), .rst(a_rst), .en(a_en), .cs(a_cs), .we(a_we),
      .addr(a_addr), .wdata(a_wdata),
      .peer_bank(bank_b), .own_bank(bank_a),
      .accept_q(a_accept_q), .emit(a_emit),
      .rdata(a_rdata), .rvalid(a_rvalid)
    );
  end else begin : g_a_off
    // R10: disabled port
    assign bank_a     = '0;
    assign a_accept_q = 1'b0;
    assign a_emit     = 1'b0;
    assign a_rdata    = '0;
    assign a_rvalid   = 1'b0;
  end

  if (B_ON) begin : g_b
    dpb_port #(
      .DW(B_DATA_W), .HW(B_HW), .AW(B_ADDR_W), .MEM_BITS(MEM_BITS),
      .CS(B_CS), .MODE(B_MODE), .OUTREG(B_OUTREG)
    ) u_port (
      .clk(b_clk), .rst(b_rst), .en(b_en), .cs(b_cs), .we(b_we),
      .addr(b_addr), .wdata(b_wdata),
      .peer_bank(bank_a), .own_bank(bank_b),
      .accept_q(b_accept_q), .emit(b_emit),
      .rdata(b_rdata), .rvalid(b_rvalid)
    );
  end else begin : g_b_off
    // R10: disabled port
    assign bank_b     = '0;
    assign b_accept_q = 1'b0;
    assign b_emit     = 1'b0;
    assign b_rdata    = '0;
    assign b_rvalid   = 1'b0;
  end
endmodule

// File: rtl/dpb_port_chk.sv
// Per-port protocol checker, bound twice onto dpb_ram.
module dpb_port_chk
  import dpb_pkg::*;
#(
  parameter int         DW   = 8,
  parameter logic [2:0] CS   = 3'd0,
  parameter wmode_e     MODE = WM_QUIET,
  parameter int         LAT  = 1,
  parameter bit         ON   = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [2:0]    cs,
  input logic          we,
  input logic          emit,
  input logic          rvalid,
  input logic [DW-1:0] rdata
);
  logic [1:0] since;
  logic       fire;

  always_ff @(posedge clk) begin
    if (rst)                since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assign fire = en && (cs == CS) && (!we || (MODE != WM_QUIET));

  if (ON) begin : g_on
    // R9: data stable while no result
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd1) && !rvalid |-> $stable(rdata));

    if (LAT == 1) begin : g_l1
      // R4 / R8: one strobe exactly one cycle after a producing request
      a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (since >= 2'd1) |-> (rvalid == $past(fire)));
      // R3: foreign select never yields a result
      a_r3_cs_ignored: assert property (@(posedge clk) disable iff (rst)
        en && (cs != CS) |=> !rvalid);
      // R8: internal emit and port strobe coincide
      a_r8_stage: assert property (@(posedge clk) disable iff (rst)
        emit |-> rvalid);
    end else begin : g_l2
      a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (since >= 2'd2) |-> (rvalid == $past(fire, 2)));
      a_r3_cs_ignored: assert property (@(posedge clk) disable iff (rst)
        en && (cs != CS) |=> ##1 !rvalid);
      a_r8_stage: assert property (@(posedge clk) disable iff (rst)
        emit |=> rvalid);
    end
  end
endmodule

bind dpb_ram dpb_port_chk #(
  .DW(A_PW), .CS(A_CS), .MODE(A_MODE), .LAT(A_LAT), .ON(A_ON)
) u_chk_a (
  .clk(a_clk), .rst(a_rst), .en(a_en), .cs(a_cs), .we(a_we),
  .emit(a_emit), .rvalid(a_rvalid), .rdata(a_rdata)
);

bind dpb_ram dpb_port_chk #(
  .DW(B_PW), .CS(B_CS), .MODE(B_MODE), .LAT(B_LAT), .ON(B_ON)
) u_chk_b (
  .clk(b_clk), .rst(b_rst), .en(b_en), .cs(b_cs), .we(b_we),
  .emit(b_emit), .rvalid(b_rvalid), .rdata(b_rdata)
);

// File: tb/tb_dpb_ram.sv
module tb_dpb_ram;
  import dpb_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  // dut: A = 8-bit (native 9), old-value, no outreg, sel 5; B = 18-bit, new-value, outreg, sel 2
  logic a_en, a_we; logic [2:0] a_cs; logic [5:0] a_addr; logic [7:0] a_wdata, a_rdata; logic a_rvalid;
  logic b_en, b_we; logic [2:0] b_cs; logic [4:0] b_addr; logic [17:0] b_wdata, b_rdata; logic b_rvalid;
  // dut2: A = 3-bit (native 4), quiet, outreg, sel 0; B disabled
  logic c_en, c_we; logic [2:0] c_cs; logic [6:0] c_addr; logic [2:0] c_wdata, c_rdata; logic c_rvalid;
  logic d_en, d_we; logic [2:0] d_cs; logic [0:0] d_addr, d_wdata, d_rdata; logic d_rvalid;

  dpb_ram #(
    .A_DATA_W(8), .A_ADDR_W(6), .A_CS(3'd5), .A_MODE(WM_ECHO_OLD), .A_OUTREG(1'b0),
    .B_DATA_W(18), .B_ADDR_W(5), .B_CS(3'd2), .B_MODE(WM_ECHO_NEW), .B_OUTREG(1'b1)
  ) dut (
    .a_clk(clk), .a_rst(rst), .a_en(a_en), .a_cs(a_cs), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(clk), .b_rst(rst), .b_en(b_en), .b_cs(b_cs), .b_we(b_we), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  dpb_ram #(
    .A_DATA_W(3), .A_ADDR_W(7), .A_CS(3'd0), .A_MODE(WM_QUIET), .A_OUTREG(1'b1),
    .B_DATA_W(0), .B_ADDR_W(1), .B_CS(3'd0), .B_MODE(WM_QUIET), .B_OUTREG(1'b0)
  ) dut2 (
    .a_clk(clk), .a_rst(rst), .a_en(c_en), .a_cs(c_cs), .a_we(c_we), .a_addr(c_addr),
    .a_wdata(c_wdata), .a_rdata(c_rdata), .a_rvalid(c_rvalid),
    .b_clk(clk), .b_rst(rst), .b_en(d_en), .b_cs(d_cs), .b_we(d_we), .b_addr(d_addr),
    .b_wdata(d_wdata), .b_rdata(d_rdata), .b_rvalid(d_rvalid)
  );

  // bench view of the three live ports: 0 = dut.A, 1 = dut.B, 2 = dut2.A
  function automatic int hwp(int p);  case (p) 0: return 9; 1: return 18; default: return 4; endcase endfunction
  function automatic int dwp(int p);  case (p) 0: return 8; 1: return 18; default: return 3; endcase endfunction
  function automatic int latp(int p); case (p) 0: return 1; default: return 2; endcase endfunction
  // 0 quiet, 1 return new, 2 return old
  function automatic int modep(int p); case (p) 0: return 2; 1: return 1; default: return 0; endcase endfunction
  function automatic int csp(int p);  case (p) 0: return 5; 1: return 2; default: return 0; endcase endfunction

  bit [575:0] m0;  // shared bits of dut
  bit [511:0] m1;  // bits of dut2

  function automatic bit [17:0] trunc(int p, bit [17:0] v);
    int mask = (1 << dwp(p)) - 1;
    return v & 18'(mask);
  endfunction

  function automatic bit [17:0] mread(int p, int addr);
    bit [17:0] r = '0;
    for (int i = 0; i < hwp(p); i++) r[i] = (p == 2) ? m1[addr*4+i] : m0[addr*hwp(p)+i];
    return r;
  endfunction

  task automatic mwrite(int p, int addr, bit [17:0] v);
    for (int i = 0; i < hwp(p); i++) begin
      if (p == 2) m1[addr*4+i] = v[i];
      else        m0[addr*hwp(p)+i] = v[i];
    end
  endtask

  typedef struct { int due; bit [17:0] data; string tag; } exp_t;
  exp_t sb[3][$];
  bit [17:0] last[3];
  bit mon_on = 1'b0;

  task automatic check(string rq, bit ok, bit [17:0] act, bit [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(int p, bit en, bit [2:0] cs, bit we, int addr, bit [17:0] d);
    case (p)
      0: begin a_en = en; a_cs = cs; a_we = we; a_addr = 6'(addr); a_wdata = 8'(d); end
      1: begin b_en = en; b_cs = cs; b_we = we; b_addr = 5'(addr); b_wdata = d; end
      2: begin c_en = en; c_cs = cs; c_we = we; c_addr = 7'(addr); c_wdata = 3'(d); end
      default: begin d_en = en; d_cs = cs; d_we = we; d_addr = 1'(addr); d_wdata = 1'(d); end
    endcase
  endtask

  // driver: one request for one cycle, expectation pushed to the scoreboard
  task automatic req(int p, bit [2:0] cs, bit we, int addr, bit [17:0] d, string tag);
    bit [17:0] old, dt;
    exp_t e;
    drive(p, 1'b1, cs, we, addr, d);
    if (cs == 3'(csp(p))) begin
      old = mread(p, addr);
      dt  = trunc(p, d);
      if (we) mwrite(p, addr, dt);
      if (!we || modep(p) != 0) begin
        e.due  = cyc + latp(p);
        e.data = (we && modep(p) == 1) ? dt : trunc(p, old);
        e.tag  = tag;
        sb[p].push_back(e);
      end
    end
    @(negedge clk);
    drive(p, 1'b0, 3'd0, 1'b0, 0, 18'd0);
  endtask

  task automatic watch(int p, bit v, bit [17:0] d);
    if (v) begin
      if (sb[p].size() == 0) begin
        check($sformatf("R8 unexpected strobe port%0d", p), 1'b0, 18'(v), 18'd0);
      end else begin
        exp_t e = sb[p].pop_front();
        check($sformatf("%s port%0d cycle", e.tag, p), cyc == e.due, 18'(cyc), 18'(e.due));
        check($sformatf("%s port%0d data", e.tag, p), d == e.data, d, e.data);
      end
      last[p] = d;
    end else begin
      check($sformatf("R9 hold port%0d", p), d == last[p], d, last[p]);
      if (sb[p].size() != 0 && sb[p][0].due <= cyc) begin
        check($sformatf("R4 missing result %s port%0d", sb[p][0].tag, p), 1'b0, 18'(cyc), 18'(sb[p][0].due));
        void'(sb[p].pop_front());
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      watch(0, a_rvalid, 18'(a_rdata));
      watch(1, b_rvalid, b_rdata);
      watch(2, c_rvalid, 18'(c_rdata));
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    check("watchdog expired", 1'b0, 18'd0, 18'd1);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    for (int p = 0; p < 4; p++) drive(p, 1'b0, 3'd0, 1'b0, 0, 18'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check("R12 reset a_rvalid/a_rdata", !a_rvalid && a_rdata == 8'd0, 18'(a_rdata), 18'd0);
    check("R12 reset b_rvalid/b_rdata", !b_rvalid && b_rdata == 18'd0, b_rdata, 18'd0);
    check("R12 reset c_rvalid/c_rdata", !c_rvalid && c_rdata == 3'd0, 18'(c_rdata), 18'd0);
    mon_on = 1'b1;

    // R6 / R4: wide port writes return written data after 2 cycles
    req(1, 3'd2, 1'b1, 0, 18'h2A5C3, "R6 new-value write");
    req(1, 3'd2, 1'b1, 1, 18'h1FF80, "R6 new-value write");
    req(1, 3'd2, 1'b1, 2, 18'h00123, "R6 new-value write");
    req(1, 3'd2, 1'b1, 3, 18'h3FFFF, "R6 new-value write");
    repeat (3) @(negedge clk);

    // R11 / R1 / R4: narrow port reads the halves, truncated to 8 bits, 1 cycle
    for (int k = 0; k < 8; k++) req(0, 3'd5, 1'b0, k, 18'd0, "R11 cross-width read");
    repeat (2) @(negedge clk);

    // R7: old-value write then read-back
    req(0, 3'd5, 1'b1, 2, 18'h0F0, "R7 old-value write");
    req(0, 3'd5, 1'b0, 2, 18'd0, "R7 read after write");
    repeat (2) @(negedge clk);
    // R1: wide view shows the zero-extended 9th bit
    req(1, 3'd2, 1'b0, 1, 18'd0, "R1 zero-extend via wide read");
    repeat (3) @(negedge clk);

    // R3: foreign select ignored on both ports
    req(0, 3'd3, 1'b1, 2, 18'h011, "R3 foreign write");
    req(1, 3'd0, 1'b0, 0, 18'd0, "R3 foreign read");
    repeat (3) @(negedge clk);
    req(0, 3'd5, 1'b0, 2, 18'd0, "R3 data unchanged");
    repeat (2) @(negedge clk);

    // R8: back-to-back strobes
    req(1, 3'd2, 1'b0, 0, 18'd0, "R8 back-to-back");
    req(1, 3'd2, 1'b0, 2, 18'd0, "R8 back-to-back");
    req(1, 3'd2, 1'b0, 3, 18'd0, "R8 back-to-back");
    req(0, 3'd5, 1'b0, 0, 18'd0, "R8 back-to-back");
    req(0, 3'd5, 1'b0, 1, 18'd0, "R8 back-to-back");
    repeat (3) @(negedge clk);

    // R5: quiet writes produce nothing; reads still return data
    for (int k = 0; k < 6; k++) req(2, 3'd0, 1'b1, k, 18'(k * 3), "R5 quiet write");
    req(2, 3'd0, 1'b1, 127, 18'h5, "R2 top address write");
    req(2, 3'd0, 1'b1, 6, 18'h3F, "R1 truncating write");
    repeat (3) @(negedge clk);
    for (int k = 0; k < 7; k++) req(2, 3'd0, 1'b0, k, 18'd0, "R5 read");
    req(2, 3'd0, 1'b0, 127, 18'd0, "R2 top address read");
    repeat (3) @(negedge clk);

    // R10: disabled port stays silent under any input
    for (int k = 0; k < 4; k++) begin
      drive(3, 1'b1, 3'd0, k[0], k, 18'd1);
      @(negedge clk);
      check("R10 disabled port quiet", !d_rvalid && d_rdata == 1'b0, 18'({d_rvalid, d_rdata}), 18'd0);
    end
    drive(3, 1'b0, 3'd0, 1'b0, 0, 18'd0);
    repeat (3) @(negedge clk);

    // R12: reset kills a result in flight on the registered port
    check("R12 precondition b_rdata nonzero", b_rdata != 18'd0, b_rdata, 18'd1);
    drive(1, 1'b1, 3'd2, 1'b0, 3, 18'd0);
    @(negedge clk);
    drive(1, 1'b0, 3'd0, 1'b0, 0, 18'd0);
    rst = 1'b1;
    for (int p = 0; p < 3; p++) last[p] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R12 no strobe after reset", !b_rvalid, 18'(b_rvalid), 18'd0);
    check("R12 b_rdata cleared", b_rdata == 18'd0, b_rdata, 18'd0);
    check("R12 a_rdata cleared", a_rdata == 8'd0, 18'(a_rdata), 18'd0);
    repeat (4) @(negedge clk);
    check("R12 no late strobe", !b_rvalid && b_rdata == 18'd0, b_rdata, 18'd0);

    // R8: everything expected was delivered
    for (int p = 0; p < 3; p++)
      check($sformatf("R8 scoreboard drained port%0d", p), sb[p].size() == 0, 18'(sb[p].size()), 18'd0);

    summary();
    $finish;
  end
endmodule